// File: doc/BRIEF.md
# Interrupt CPU-Target Register Bank

This block holds, for every implemented interrupt of an interrupt distributor, one byte that names the CPUs the interrupt may be delivered to. Bit n of an interrupt's byte selects CPU n. Software reaches the bytes through a small register bus. The bus carries a byte address, 32-bit write data, four byte-lane enables, a write strobe and a read strobe. The bus word at window offset 4k holds interrupts 4k to 4k+3. Interrupt 4k+j sits in byte lane j. The low two address bits are ignored, so a byte access is made by enabling a single lane.

The bank is sized by two parameters: the number of implemented CPUs (1 to 8) and the number of implemented interrupts. Target bits for CPUs that do not exist are not stored. They read as zero, and writes to them are dropped. The same applies to whole bytes whose interrupt number is at or past the implemented count. The same mask repeats in every byte lane. Every stored byte is also driven out in parallel, so routing logic downstream can use the targets without going through the bus.

Top module: `irq_target_bank`

## Requirements
- R1: After reset is asserted, every target byte is zero, both on `targets_o` and through the bus.
- R2: A write with all four lanes enabled stores the write data ANDed with the CPU mask repeated in each byte. With two CPUs, writing 0x0103020F reads back as 0x01030203.
- R3: Bits at positions equal to or above NUM_CPUS always read zero and ignore writes. With NUM_CPUS = 8, every bit is stored as written.
- R4: A write changes only the bytes whose lane enable is set. The other bytes of that word keep their value.
- R5: A read returns the masked target byte in each lane whose enable is set, and zero in lanes whose enable is clear.
- R6: Read data is valid on `rdata_o` in the cycle after the clock edge that samples `rd_i` high. In the cycle after an edge with `rd_i` low, `rdata_o` is zero.
- R7: A byte lane whose interrupt number (window offset rounded down to a word, plus lane) is at or beyond NUM_IRQS reads zero, and writes to it change nothing.
- R8: Addresses outside the window [BASE_ADDR, BASE_ADDR + WIN_BYTES) read zero, and writes to them change no state.
- R9: `targets_o[8*i +: 8]` always carries the current masked target byte of interrupt i.
- R10: The word at window offset 4k maps interrupt 4k+j to `wdata_i`/`rdata_o` bits [8j+7:8j], so the lowest-numbered interrupt is in the least significant byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address in the distributor space; bits [1:0] ignored |
| wdata_i | input | 32 | Write data, one byte per interrupt |
| be_i | input | 4 | Byte-lane enables for both reads and writes |
| wr_i | input | 1 | Write strobe; enabled lanes update at this clock edge |
| rd_i | input | 1 | Read strobe; data appears one cycle later |
| rdata_o | output | 32 | Registered read data |
| targets_o | output | 8*NUM_IRQS | Parallel copy of every interrupt's masked target byte |

## Verification
The assertions assume that `rd_i`, `wr_i`, `addr_i` and `be_i` are driven to known values from reset onward. They also assume that a read and a write never share a cycle, so the stability checks on `targets_o` see only one bus operation at a time. The stimulus follows these assumptions. Every input changes only on the falling clock edge. Strobes are held low between operations. Reads and writes are issued as separate single-cycle tasks, with idle cycles between them.

// File: rtl/itb_pkg.sv
package itb_pkg;
  localparam int unsigned LANES = 4;

  typedef logic [7:0] tgt_byte_t;

  function automatic tgt_byte_t cpu_mask(input int unsigned n_cpus);
    tgt_byte_t m;
    m = '0;
    for (int unsigned b = 0; b < 8; b++) begin
      if (b < n_cpus) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [LANES-1:0] be);
    logic [31:0] m;
    for (int unsigned k = 0; k < LANES; k++) m[k*8 +: 8] = {8{be[k]}};
    return m;
  endfunction
endpackage

// File: rtl/itb_decode.sv
module itb_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 32'h800,
  parameter int unsigned WIN_BYTES = 1024,
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned WIDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              word_ok_o,
  output logic [WIDX_W-1:0] widx_o
);
  logic [31:0] a_ext;
  logic [31:0] word_full;
  logic        in_win;

  always_comb begin
    a_ext     = 32'(addr_i);
    in_win    = (a_ext >= BASE_ADDR) && (a_ext < BASE_ADDR + WIN_BYTES);
    word_full = (a_ext - BASE_ADDR) >> 2;
    // only words holding at least one storage slot decode as a hit
    word_ok_o = in_win && (word_full < NUM_WORDS);
    widx_o    = WIDX_W'(word_full);
  end
endmodule

// File: rtl/itb_slot.sv
module itb_slot #(
  parameter int unsigned NUM_CPUS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [NUM_CPUS-1:0] wbits_i,
  output logic [7:0]          tgt_o
);
  logic [NUM_CPUS-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wbits_i;
  end

  generate
    if (NUM_CPUS < 8) begin : g_pad
      assign tgt_o = {{(8-NUM_CPUS){1'b0}}, q};
    end else begin : g_full
      assign tgt_o = q;
    end
  endgenerate
endmodule

// File: rtl/itb_rdport.sv
module itb_rdport #(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned WIDX_W    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_i,
  input  logic                  hit_i,
  input  logic [WIDX_W-1:0]     widx_i,
  input  logic [3:0]            be_i,
  input  logic [NUM_WORDS*32-1:0] words_i,
  output logic [31:0]           rdata_o
);
  import itb_pkg::*;

  logic [31:0] sel_word;
  logic [31:0] rdata_q;

  always_comb begin
    sel_word = '0;
    for (int unsigned w = 0; w < NUM_WORDS; w++) begin
      if (widx_i == WIDX_W'(w)) sel_word = words_i[w*32 +: 32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (rd_i && hit_i)   rdata_q <= sel_word & lane_mask(be_i);
    else                      rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank #(
  parameter int unsigned NUM_CPUS  = 8,
  parameter int unsigned NUM_IRQS  = 64,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 32'h800,
  parameter int unsigned WIN_BYTES = 1024
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  input  logic [3:0]            be_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  output logic [31:0]           rdata_o,
  output logic [NUM_IRQS*8-1:0] targets_o
);
  localparam int unsigned NUM_WORDS = (NUM_IRQS + 3) / 4;
  localparam int unsigned NUM_SLOTS = NUM_WORDS * 4;
  localparam int unsigned WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic                   word_ok;
  logic [WIDX_W-1:0]      widx;
  logic [NUM_SLOTS*8-1:0] slot_bytes;

  itb_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .WIN_BYTES(WIN_BYTES),
    .NUM_WORDS(NUM_WORDS),
    .WIDX_W   (WIDX_W)
  ) u_decode (
    .addr_i   (addr_i),
    .word_ok_o(word_ok),
    .widx_o   (widx)
  );

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      localparam int unsigned WORD = i / 4;
      localparam int unsigned LANE = i % 4;
      if (i < NUM_IRQS) begin : g_impl
        logic       we;
        logic [7:0] tgt;
        assign we = wr_i && word_ok && be_i[LANE] && (widx == WIDX_W'(WORD));
        itb_slot #(.NUM_CPUS(NUM_CPUS)) u_slot (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .we_i   (we),
          .wbits_i(wdata_i[LANE*8 +: NUM_CPUS]),
          .tgt_o  (tgt)
        );
        assign slot_bytes[i*8 +: 8] = tgt;
        assign targets_o[i*8 +: 8]  = tgt;
      end else begin : g_absent
        assign slot_bytes[i*8 +: 8] = 8'h00;
      end
    end
  endgenerate

  itb_rdport #(
    .NUM_WORDS(NUM_WORDS),
    .WIDX_W   (WIDX_W)
  ) u_rdport (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .hit_i  (word_ok),
    .widx_i (widx),
    .be_i   (be_i),
    .words_i(slot_bytes),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/itb_checker.sv
module itb_checker #(
  parameter int unsigned NUM_CPUS  = 8,
  parameter int unsigned NUM_IRQS  = 64,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 32'h800,
  parameter int unsigned WIN_BYTES = 1024
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [3:0]            be_i,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [31:0]           rdata_o,
  input logic [NUM_IRQS*8-1:0] targets_o
);
  import itb_pkg::*;

  localparam logic [7:0] BYTE_MASK = cpu_mask(NUM_CPUS);

  logic [31:0] a_ext;
  logic        in_win;
  logic        word_absent;

  assign a_ext       = 32'(addr_i);
  assign in_win      = (a_ext >= BASE_ADDR) && (a_ext < BASE_ADDR + WIN_BYTES);
  assign word_absent = in_win && (((a_ext - BASE_ADDR) & ~32'd3) >= NUM_IRQS);

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0); // R6
  AST_OUTSIDE_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !in_win) |=> rdata_o == '0); // R8
  AST_OUTSIDE_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && in_win) |=> $stable(targets_o)); // R8
  AST_ABSENT_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && word_absent) |=> rdata_o == '0); // R7
  AST_ABSENT_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word_absent) |=> $stable(targets_o)); // R7
  AST_CPU_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (targets_o & ~{NUM_IRQS{BYTE_MASK}}) == '0); // R3

  generate
    for (genvar k = 0; k < 4; k++) begin : g_lane
      AST_LANE_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !be_i[k]) |=> rdata_o[k*8 +: 8] == 8'h00); // R5
    end
  endgenerate
endmodule

bind irq_target_bank itb_checker #(
  .NUM_CPUS (NUM_CPUS),
  .NUM_IRQS (NUM_IRQS),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR),
  .WIN_BYTES(WIN_BYTES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .be_i     (be_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .targets_o(targets_o)
);

// File: tb/irq_target_bank_test.sv
`timescale 1ns/1ps
module irq_target_bank_test;
  localparam int unsigned NIRQ = 42;
  localparam logic [7:0]  MASK_A = 8'h03;

  typedef struct {
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    string       tag;
  } rd_item_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  be_i = '0;
  logic wr_i = 1'b0;
  logic rd_i = 1'b0;
  logic [31:0] rdata_a, rdata_b;
  logic [NIRQ*8-1:0] tg_a, tg_b;

  logic [7:0] m_a [NIRQ];
  logic [7:0] m_b [NIRQ];
  rd_item_t   sb_q [$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_target_bank #(.NUM_CPUS(2), .NUM_IRQS(NIRQ)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .be_i(be_i), .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_a), .targets_o(tg_a));

  irq_target_bank #(.NUM_CPUS(8), .NUM_IRQS(NIRQ)) uut_full (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .be_i(be_i), .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_b), .targets_o(tg_b));

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input bit full, input logic [11:0] addr,
                                          input logic [3:0] be);
    logic [31:0] r;
    int unsigned off;
    r = '0;
    if (addr >= 12'h800) begin
      off = (int'(addr) - 32'h800) & ~32'd3;
      for (int j = 0; j < 4; j++) begin
        if (be[j] && (off + j) < NIRQ) r[j*8 +: 8] = full ? m_b[off+j] : m_a[off+j];
      end
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NIRQ; i++) begin
      m_a[i] = 8'h00;
      m_b[i] = 8'h00;
    end
  endtask

  task automatic bus_write(input logic [11:0] addr, input logic [31:0] d, input logic [3:0] be);
    int unsigned off;
    @(negedge clk_i);
    addr_i = addr; wdata_i = d; be_i = be; wr_i = 1'b1;
    if (addr >= 12'h800) begin
      off = (int'(addr) - 32'h800) & ~32'd3;
      for (int j = 0; j < 4; j++) begin
        if (be[j] && (off + j) < NIRQ) begin
          m_a[off+j] = d[j*8 +: 8] & MASK_A;
          m_b[off+j] = d[j*8 +: 8];
        end
      end
    end
    @(negedge clk_i);
    wr_i = 1'b0; be_i = '0;
  endtask

  task automatic bus_read(input logic [11:0] addr, input logic [3:0] be, input string tag);
    rd_item_t it;
    @(negedge clk_i);
    addr_i = addr; be_i = be; rd_i = 1'b1;
    it.exp_a = exp_rd(1'b0, addr, be);
    it.exp_b = exp_rd(1'b1, addr, be);
    it.tag   = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
    rd_i = 1'b0; be_i = '0;
  endtask

  task automatic check_targets(input string tag);
    logic [NIRQ*8-1:0] ea, eb;
    for (int i = 0; i < NIRQ; i++) begin
      ea[i*8 +: 8] = m_a[i];
      eb[i*8 +: 8] = m_b[i];
    end
    checks += 2;
    if (tg_a !== ea) begin
      failures++;
      $display("FAIL %s uut targets: actual %h expected %h", tag, tg_a, ea);
    end
    if (tg_b !== eb) begin
      failures++;
      $display("FAIL %s uut_full targets: actual %h expected %h", tag, tg_b, eb);
    end
  endtask

  // monitor: pops one scoreboard item per sampled read strobe
  initial begin
    forever begin
      @(posedge clk_i);
      if (rd_i && rst_ni) begin
        rd_item_t it;
        #1;
        if (sb_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R6: read data without expectation");
        end else begin
          it = sb_q.pop_front();
          check32({it.tag, " uut"}, rdata_a, it.exp_a);
          check32({it.tag, " uut_full"}, rdata_b, it.exp_b);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    check_targets("R1 reset");
    bus_read(12'h800, 4'hF, "R1 reset read");

    bus_write(12'h820, 32'h0103020F, 4'hF);
    bus_read(12'h820, 4'hF, "R2 word masked / R3 full width");
    bus_write(12'h804, 32'hFFFFFFFF, 4'hF);
    bus_read(12'h804, 4'hF, "R3 absent cpu bits");

    bus_read(12'h821, 4'b0010, "R5 byte read lane1");
    bus_read(12'h820, 4'b1001, "R5 lanes 0 and 3");

    bus_write(12'h822, 32'h00040000, 4'b0100);
    bus_read(12'h820, 4'hF, "R4 byte write lane2");
    bus_write(12'h804, 32'h00000000, 4'b0010);
    bus_read(12'h804, 4'hF, "R4 byte write lane1");

    bus_write(12'h80C, 32'h01020301, 4'hF);
    check_targets("R9 R10 export order");

    bus_write(12'h828, 32'hFFFFFFFF, 4'hF);
    bus_read(12'h828, 4'hF, "R7 partial word");
    bus_write(12'h82C, 32'h01010101, 4'hF);
    bus_read(12'h82C, 4'hF, "R7 absent word");
    bus_read(12'hBFC, 4'hF, "R7 window top");
    check_targets("R7 no state change");

    bus_write(12'h400, 32'hFFFFFFFF, 4'hF);
    bus_write(12'h7FC, 32'hFFFFFFFF, 4'hF);
    check_targets("R8 outside writes ignored");
    bus_read(12'h7FC, 4'hF, "R8 below window");
    bus_read(12'h400, 4'hF, "R8 far outside");

    @(negedge clk_i);
    check32("R6 idle rdata uut", rdata_a, 32'h0);
    check32("R6 idle rdata uut_full", rdata_b, 32'h0);

    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk_i);
    check_targets("R1 reset mid-run");
    rst_ni = 1'b1;
    bus_read(12'h820, 4'hF, "R1 read after reset");

    repeat (3) @(negedge clk_i);
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R6: actual %0d pending reads expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule